// File: doc/BRIEF.md
# Stream Cipher Keystream Core

This core encrypts or decrypts a stream of 32-bit data words for an inline storage path. At the start of a session a host presents a 256-bit key, a 96-bit nonce and a starting block counter with a one-cycle load strobe. The core then builds a 16-word state and runs twenty ARX rounds on it, alternating column and diagonal quarter-round passes, one pass per cycle. It adds the original state back into the result to form a 512-bit keystream block. Each data word that arrives is XORed with the next keystream word. Because the same operation encrypts and decrypts, a single instance serves both directions.

The core is built for low area. The feed-forward addition goes through one shared 32-bit adder, one word per cycle, and the keystream is held in the same registers as the working state. Once the sixteenth data word of a block has been accepted, the block counter advances by one. The next block is then computed while the input is stalled, and `busy` is high for that time. The design is timed for a 50 MHz clock.

Top module: `ks_stream_core`

## Requirements
- R1: Out of reset, `busy`, `din_ready` and `dout_valid` are all low, and no data is accepted until a key has been loaded.
- R2: After a load strobe, `busy` is high for exactly 37 cycles: 1 cycle of state setup, 20 round cycles and 16 serial feed-forward cycles. `din_ready` then rises if the output register has room.
- R3: The keystream block equals the standard 20-round ARX block function with the quarter-round rotations 16, 12, 8 and 7, with the original state added word by word modulo 2^32. The block for key bytes 0x00..0x1f, nonce words {0x09000000, 0x4a000000, 0x00000000} and counter 1 starts with the words 0xe4e7f110 and 0x15593bd1.
- R4: Feeding ciphertext back under the same key, nonce and counter returns the original plaintext.
- R5: Within a block, the n-th accepted data word (n = 0..15) is XORed with keystream word n.
- R6: After the sixteenth word of a block is accepted, the counter increments by one. The next block is computed with `busy` high for 37 cycles, and that block uses the new counter.
- R7: While `busy` is high, `din_ready` is low and `din_valid` is ignored: no output word appears.
- R8: While `dout_valid` is high and `dout_ready` is low, `dout` and `dout_valid` hold and `din_ready` is low.
- R9: State layout: words 0..3 hold the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Word 4+j holds `key_i[32j+31:32j]`, word 12 the block counter, and word 13+j holds `nonce_i[32j+31:32j]`.
- R10: The block counter wraps from 0xffffffff to 0 modulo 2^32.
- R11: A load in the middle of a block discards the rest of that block. The next accepted word is XORed with word 0 of the new key's block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle strobe that captures key, nonce and counter |
| key_i | input | 256 | Session key, word j in bits 32j+31:32j |
| nonce_i | input | 96 | Nonce, word j in bits 32j+31:32j |
| blkctr_i | input | 32 | Starting block counter |
| din_valid | input | 1 | Input word valid |
| din_ready | output | 1 | Core accepts an input word |
| din | input | 32 | Input data word |
| dout_valid | output | 1 | Output word valid |
| dout_ready | input | 1 | Consumer accepts the output word |
| dout | output | 32 | Input word XOR keystream word |
| busy | output | 1 | A keystream block is being computed |

## Verification
An error in the round logic or in the serial adder does not stay inside the core. The first block after a load carries it to `dout` within 38 cycles of the strobe. A bad round pass corrupts all sixteen words, while a bad feed-forward slot corrupts exactly one word position. A counter that fails to step or to wrap is only visible from the seventeenth word onward, so the checks run several blocks in sequence. A known-answer block computed independently in the bench fixes the absolute values. Stall errors show within a cycle as `din_ready` high while `busy`, or as `dout` changing under back-pressure.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BLK_WORDS   = 16;
  localparam int unsigned KEY_WORDS   = 8;
  localparam int unsigned NONCE_WORDS = 3;
  localparam int unsigned IDX_W       = $clog2(BLK_WORDS);
  localparam int unsigned KEY_BITS    = KEY_WORDS * WORD_W;
  localparam int unsigned NONCE_BITS  = NONCE_WORDS * WORD_W;
  localparam int unsigned CTR_POS     = 4 + KEY_WORDS;
  localparam int unsigned NONCE_POS   = CTR_POS + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [BLK_WORDS-1:0] blk_t;
  typedef word_t [KEY_WORDS-1:0] key_t;
  typedef word_t [NONCE_WORDS-1:0] nonce_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  typedef enum logic [2:0] {
    PH_EMPTY,
    PH_SETUP,
    PH_ROUND,
    PH_FEED,
    PH_SERVE
  } phase_e;

  function automatic word_t rol(word_t x, int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t sigma_word(int unsigned i);
    case (i)
      0:       return 32'h61707865;
      1:       return 32'h3320646e;
      2:       return 32'h79622d32;
      default: return 32'h6b206574;
    endcase
  endfunction

  // One ARX quarter-round on four words.
  function automatic quad_t quarter(quad_t q);
    quad_t r;
    r = q;
    r.a = r.a + r.b; r.d = rol(r.d ^ r.a, 16);
    r.c = r.c + r.d; r.b = rol(r.b ^ r.c, 12);
    r.a = r.a + r.b; r.d = rol(r.d ^ r.a, 8);
    r.c = r.c + r.d; r.b = rol(r.b ^ r.c, 7);
    return r;
  endfunction

  // Index of element 'pos' of quarter-round 'lane' in a column or diagonal pass.
  function automatic logic [IDX_W-1:0] lane_index(logic diag, int unsigned lane,
                                                  int unsigned pos);
    int unsigned col;
    col = diag ? ((lane + pos) % 4) : lane;
    return IDX_W'(4 * pos + col);
  endfunction
endpackage

// File: rtl/ks_round_unit.sv
module ks_round_unit
  import ks_pkg::*;
(
  input  blk_t st_in,
  input  logic diag,
  output blk_t st_out
);
  quad_t qi [4];
  quad_t qo [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign qi[g] = '{a: st_in[lane_index(diag, g, 0)],
                     b: st_in[lane_index(diag, g, 1)],
                     c: st_in[lane_index(diag, g, 2)],
                     d: st_in[lane_index(diag, g, 3)]};
    assign qo[g] = quarter(qi[g]);
  end

  always_comb begin
    st_out = st_in;
    for (int l = 0; l < 4; l++) begin
      st_out[lane_index(diag, l, 0)] = qo[l].a;
      st_out[lane_index(diag, l, 1)] = qo[l].b;
      st_out[lane_index(diag, l, 2)] = qo[l].c;
      st_out[lane_index(diag, l, 3)] = qo[l].d;
    end
  end
endmodule

// File: rtl/ks_feed_seq.sv
module ks_feed_seq
  import ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  word_t            work_w,
  input  word_t            orig_w,
  output logic [IDX_W-1:0] idx,
  output word_t            sum,
  output logic             last
);
  // The only feed-forward adder: one state word per cycle.
  assign sum  = work_w + orig_w;
  assign last = run && (idx == IDX_W'(BLK_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (run) idx <= idx + 1'b1;
    else          idx <= '0;
  end
endmodule

// File: rtl/ks_out_stage.sv
module ks_out_stage
  import ks_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  word_t value,
  input  logic  ready_in,
  output logic  valid,
  output word_t data,
  output logic  room
);
  assign room = !valid || ready_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      data  <= value;
    end else if (ready_in) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ks_stream_core.sv
module ks_stream_core
  import ks_pkg::*;
#(
  parameter int unsigned ROUNDS = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [KEY_BITS-1:0]   key_i,
  input  logic [NONCE_BITS-1:0] nonce_i,
  input  logic [WORD_W-1:0]     blkctr_i,
  input  logic                  din_valid,
  output logic                  din_ready,
  input  logic [WORD_W-1:0]     din,
  output logic                  dout_valid,
  input  logic                  dout_ready,
  output logic [WORD_W-1:0]     dout,
  output logic                  busy
);
  localparam int unsigned RC_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(ROUNDS - 1);
  localparam logic [IDX_W-1:0] W_LAST = IDX_W'(BLK_WORDS - 1);

  phase_e           phase;
  key_t             key_q;
  nonce_t           nonce_q;
  word_t            ctr_q;
  blk_t             init_st;
  blk_t             ws;
  blk_t             rnd_out;
  logic [RC_W-1:0]  rcnt;
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] fidx;
  word_t            fsum;
  logic             flast;
  logic             out_room;

  // Named internal events, also used by the checker.
  logic feed_run, round_step, word_take, blk_roll;
  assign feed_run   = (phase == PH_FEED);
  assign round_step = (phase == PH_ROUND);
  assign din_ready  = (phase == PH_SERVE) && out_room;
  assign word_take  = din_valid && din_ready;
  assign blk_roll   = word_take && (widx == W_LAST);
  assign busy       = (phase == PH_SETUP) || (phase == PH_ROUND) || (phase == PH_FEED);

  always_comb begin
    for (int i = 0; i < 4; i++) init_st[i] = sigma_word(i);
    for (int i = 0; i < KEY_WORDS; i++) init_st[4 + i] = key_q[i];
    init_st[CTR_POS] = ctr_q;
    for (int i = 0; i < NONCE_WORDS; i++) init_st[NONCE_POS + i] = nonce_q[i];
  end

  ks_round_unit u_round (
    .st_in  (ws),
    .diag   (rcnt[0]),
    .st_out (rnd_out)
  );

  ks_feed_seq u_feed (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (feed_run),
    .work_w (ws[fidx]),
    .orig_w (init_st[fidx]),
    .idx    (fidx),
    .sum    (fsum),
    .last   (flast)
  );

  ks_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (word_take),
    .value    (din ^ ws[widx]),
    .ready_in (dout_ready),
    .valid    (dout_valid),
    .data     (dout),
    .room     (out_room)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_EMPTY;
      key_q   <= '0;
      nonce_q <= '0;
      ctr_q   <= '0;
      ws      <= '0;
      rcnt    <= '0;
      widx    <= '0;
    end else if (load_i) begin
      key_q   <= key_i;
      nonce_q <= nonce_i;
      ctr_q   <= blkctr_i;
      widx    <= '0;
      phase   <= PH_SETUP;
    end else begin
      case (phase)
        PH_SETUP: begin
          ws    <= init_st;
          rcnt  <= '0;
          phase <= PH_ROUND;
        end
        PH_ROUND: begin
          ws   <= rnd_out;
          rcnt <= rcnt + 1'b1;
          if (rcnt == RC_LAST) phase <= PH_FEED;
        end
        PH_FEED: begin
          ws[fidx] <= fsum;
          if (flast) phase <= PH_SERVE;
        end
        PH_SERVE: begin
          if (word_take) begin
            widx <= widx + 1'b1;
            if (blk_roll) begin
              ctr_q <= ctr_q + 32'd1;
              phase <= PH_SETUP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ks_stream_core_chk.sv
module ks_stream_core_chk
  import ks_pkg::*;
#(
  parameter int unsigned ROUNDS = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             busy,
  input logic             din_ready,
  input logic             dout_valid,
  input logic             dout_ready,
  input word_t            dout,
  input word_t            ctr_q,
  input logic             blk_roll,
  input logic             feed_run,
  input logic [IDX_W-1:0] fidx
);
  localparam int unsigned BUSY_CYC = 1 + ROUNDS + BLK_WORDS;

  int unsigned busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len <= 0;
    else if (load_i) busy_len <= 0;
    else if (busy)   busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  p_stall_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !din_ready);

  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy);

  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < BUSY_CYC);

  p_busy_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == BUSY_CYC);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout)));

  p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_roll && !load_i) |=> ctr_q == $past(ctr_q) + 32'd1);

  p_feed_serial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_run && $past(feed_run)) |-> fidx == $past(fidx) + 1'b1);
endmodule

bind ks_stream_core ks_stream_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .busy       (busy),
  .din_ready  (din_ready),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout       (dout),
  .ctr_q      (ctr_q),
  .blk_roll   (blk_roll),
  .feed_run   (feed_run),
  .fidx       (fidx)
);

// File: tb/tb_ks_stream_core.sv
module tb_ks_stream_core;
  localparam int BUSY_EXP = 1 + 20 + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [95:0] nonce_i = '0;
  logic [31:0] blkctr_i = '0;
  logic din_valid = 1'b0;
  logic din_ready;
  logic [31:0] din = '0;
  logic dout_valid;
  logic dout_ready = 1'b1;
  logic [31:0] dout;
  logic busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] w;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  ks_stream_core dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .nonce_i(nonce_i),
    .blkctr_i(blkctr_i), .din_valid(din_valid), .din_ready(din_ready), .din(din),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout(dout), .busy(busy)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Independent reference model of the keystream block.
  function automatic logic [127:0] tb_qr(logic [31:0] a, logic [31:0] b,
                                         logic [31:0] c, logic [31:0] d);
    a = a + b; d = d ^ a; d = {d[15:0], d[31:16]};
    c = c + d; b = b ^ c; b = {b[19:0], b[31:20]};
    a = a + b; d = d ^ a; d = {d[23:0], d[31:24]};
    c = c + d; b = b ^ c; b = {b[24:0], b[31:25]};
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] ref_block(logic [255:0] k, logic [95:0] n, logic [31:0] ctr);
    logic [31:0] x[16];
    logic [31:0] s[16];
    logic [127:0] t;
    logic [511:0] r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int j = 0; j < 8; j++) s[4 + j] = k[32*j +: 32];
    s[12] = ctr;
    for (int j = 0; j < 3; j++) s[13 + j] = n[32*j +: 32];
    for (int i = 0; i < 16; i++) x[i] = s[i];
    for (int dr = 0; dr < 10; dr++) begin
      for (int c = 0; c < 4; c++) begin
        t = tb_qr(x[c], x[c+4], x[c+8], x[c+12]);
        x[c] = t[127:96]; x[c+4] = t[95:64]; x[c+8] = t[63:32]; x[c+12] = t[31:0];
      end
      for (int c = 0; c < 4; c++) begin
        int i1, i2, i3;
        i1 = 4 + (c + 1) % 4; i2 = 8 + (c + 2) % 4; i3 = 12 + (c + 3) % 4;
        t = tb_qr(x[c], x[i1], x[i2], x[i3]);
        x[c] = t[127:96]; x[i1] = t[95:64]; x[i2] = t[63:32]; x[i3] = t[31:0];
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  // Scoreboard monitor: sample away from the active edge.
  always @(negedge clk) begin
    if (rst_n && dout_valid && dout_ready) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "unexpected output word", dout, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(dout == e.w, e.tag, dout, e.w);
      end
    end
  end

  task automatic do_load(logic [255:0] k, logic [95:0] n, logic [31:0] c);
    @(posedge clk); #2;
    key_i = k; nonce_i = n; blkctr_i = c; load_i = 1'b1;
    @(posedge clk); #2;
    load_i = 1'b0;
  endtask

  // Drives one word, pushes its expected output at the handshake.
  task automatic send_word(logic [31:0] w, logic [31:0] e, string tag);
    exp_t it;
    din = w; din_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (din_ready) begin
        it.w = e; it.tag = tag;
        sbq.push_back(it);
        @(posedge clk); #2;
        break;
      end
    end
  endtask

  task automatic send_block(logic [511:0] ks, logic [31:0] seed, int nw, string tag);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] p;
      p = seed ^ (32'h01010101 * i) ^ (i << 20);
      send_word(p, p ^ ks[32*i +: 32], tag);
    end
    din_valid = 1'b0;
  endtask

  task automatic count_busy(string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin
      n++;
      chk(din_ready == 1'b0, "R7 din_ready while busy", {31'b0, din_ready}, 32'h0);
      @(negedge clk);
    end
    chk(n == BUSY_EXP, tag, n, BUSY_EXP);
    chk(din_ready == 1'b1, {tag, " ready after busy"}, {31'b0, din_ready}, 32'h1);
    @(posedge clk); #2;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((sbq.size() != 0 || dout_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(sbq.size() == 0, "scoreboard drain", sbq.size(), 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] k1, k2, k3;
    logic [95:0] n1, n2;
    logic [511:0] b;

    for (int i = 0; i < 32; i++) k1[8*i +: 8] = 8'(i);
    n1 = 96'h00000000_4a000000_09000000;
    k2 = {8{32'h9e3779b9}} ^ {256{1'b1}} ^ (k1 << 3);
    n2 = 96'hcafef00d_12345678_0badbeef;
    k3 = ~k1;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", {31'b0, busy}, 32'h0);
    chk(din_ready == 1'b0, "R1 din_ready", {31'b0, din_ready}, 32'h0);
    chk(dout_valid == 1'b0, "R1 dout_valid", {31'b0, dout_valid}, 32'h0);
    @(posedge clk); #2; rst_n = 1'b1;
    din_valid = 1'b1; din = 32'h12345678;
    repeat (4) begin
      @(negedge clk);
      chk(din_ready == 1'b0 && dout_valid == 1'b0, "R1 no key no accept",
          {30'b0, din_ready, dout_valid}, 32'h0);
    end
    @(posedge clk); #2; din_valid = 1'b0;

    // R3: reference model known answer (R9 layout)
    b = ref_block(k1, n1, 32'd1);
    chk(b[31:0] == 32'he4e7f110, "R3 R9 model word0", b[31:0], 32'he4e7f110);
    chk(b[63:32] == 32'h15593bd1, "R3 R9 model word1", b[63:32], 32'h15593bd1);

    // R2 / R3: first block
    do_load(k1, n1, 32'd1);
    count_busy("R2 busy length");
    for (int i = 0; i < 16; i++) send_word(32'h0, b[32*i +: 32], "R3 keystream");
    din_valid = 1'b0;
    // R6: automatic next block with counter 2
    count_busy("R6 busy length");
    send_block(ref_block(k1, n1, 32'd2), 32'ha5a50000, 16, "R6 next block");
    drain();

    // R4: round trip
    do_load(k1, n1, 32'd1);
    b = ref_block(k1, n1, 32'd1);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] p;
      p = 32'h5eed0000 + i * 32'h01000103;
      send_word(p ^ b[32*i +: 32], p, "R4 decrypt");
    end
    din_valid = 1'b0;
    drain();

    // R8: back-pressure on first word of counter-2 block
    dout_ready = 1'b0;
    b = ref_block(k1, n1, 32'd2);
    send_word(32'h0f0f0f0f, 32'h0f0f0f0f ^ b[31:0], "R8 held word");
    din_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(dout_valid == 1'b1, "R8 valid held", {31'b0, dout_valid}, 32'h1);
      chk(dout == (32'h0f0f0f0f ^ b[31:0]), "R8 data held", dout, 32'h0f0f0f0f ^ b[31:0]);
      chk(din_ready == 1'b0, "R8 input stalled", {31'b0, din_ready}, 32'h0);
    end
    @(posedge clk); #2; dout_ready = 1'b1;
    drain();

    // R7: input ignored while busy, then R5 word order
    do_load(k2, n2, 32'd7);
    din = 32'hdeadbeef; din_valid = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(din_ready == 1'b0, "R7 ready low", {31'b0, din_ready}, 32'h0);
      chk(dout_valid == 1'b0, "R7 no output", {31'b0, dout_valid}, 32'h0);
    end
    @(posedge clk); #2; din_valid = 1'b0;
    b = ref_block(k2, n2, 32'd7);
    for (int i = 0; i < 16; i++) send_word(32'(i), 32'(i) ^ b[32*i +: 32], "R5 word order");
    din_valid = 1'b0;

    // R11: partial block then reload
    send_block(ref_block(k2, n2, 32'd8), 32'h33330000, 5, "R11 partial");
    do_load(k3, n2, 32'd100);
    send_block(ref_block(k3, n2, 32'd100), 32'h77770000, 16, "R11 restart word0");
    drain();

    // R10: counter wrap
    do_load(k2, n1, 32'hffffffff);
    send_block(ref_block(k2, n1, 32'hffffffff), 32'h0, 16, "R10 last counter");
    send_block(ref_block(k2, n1, 32'h0), 32'h0, 16, "R10 wrapped counter");
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule